// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs one read or write machine cycle at a time on a bus whose low 16 lines carry first the address and then the data, and whose upper four lines carry the top address bits and then status. A client presents a request with the 20-bit address, a memory-or-I/O flag, a direction flag, a flag for use of the upper byte lane, the segment in use and the write data. The block accepts the request and walks the bus through T1, T2, T3, any number of wait states (Tw) and T4. The controller behaves like a 16-bit processor in single-processor mode.

All pins are modelled as separate output-value and output-enable signals, plus an input copy of the low lines. A pad ring or a bus model joins them into real tristate pins. The block samples a ready input to stretch slow transfers. It captures read data into a response register. It gives up the bus to another master between machine cycles when asked, and floats every driven pin while the bus is handed over. Each T-state lasts one clock.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is high exactly when the phase is idle or T4 and `hold_req` is low. A request with `req_valid` high at such an edge starts T1 in the next cycle. The order after that is always T1, T2, T3, zero or more Tw, T4.
- R2: `ale` is high for the single cycle of T1 and low in every other phase.
- R3: In T1 `ad_out` carries address bits 15..0 with `ad_oe` high. In T2, T3, Tw and T4 of a write, `ad_out` carries the write data with `ad_oe` high. In those phases of a read, and in idle and hold, `ad_oe` is low and `ad_out` is zero.
- R4: In T1, `ast_out` carries address bits 19..16 for a memory cycle and 0000 for an I/O cycle.
- R5: In T2, T3, Tw and T4, `ast_out` is {S6, S5, S4, S3}. S6 is 0 and S5 is the interrupt-enable status. S4S3 is the segment code (00 extra, 01 stack, 10 code or none, 11 data). An I/O cycle always shows 10. Outside a cycle `ast_out` is zero.
- R6: S5 shows the value of `ie_flag` registered at the previous clock edge, and it tracks that value on every cycle of the data phases.
- R7: `bhe_n` in T1 is the inverse of the request's upper-lane flag. In all later phases, and outside a cycle, it is 1 (status S7 held high).
- R8: `rd_n` is low only in T2, T3 and Tw of a read cycle.
- R9: `ready` is sampled at the edge that ends T3 and at the edge that ends each Tw. If it is low, a Tw follows. If it is high, T4 follows.
- R10: For a read, `ad_in` is captured at the edge where `ready` is seen high. `rsp_valid` is high during that cycle's T4, and `rsp_rdata` holds the captured word.
- R11: A high `hold_req` is granted only from idle or at the end of T4, and it wins over a pending request. `hlda` is high from the next cycle for as long as `hold_req` stays high, and it drops one cycle after `hold_req` falls. While `hlda` is high, `ad_oe`, `ast_oe`, `bhe_oe` and `rd_oe` are all low.
- R12: After synchronous reset the block is idle, with `hlda` low, `ale` low, `rd_n` high, `ad_oe` low and the registered interrupt-enable status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | 20 | Physical address |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_byte | input | 1 | 1 = upper byte lane carries data |
| req_seg | input | 2 | Segment code for status S4S3 |
| req_wdata | input | 16 | Write data |
| ie_flag | input | 1 | Interrupt-enable flag shown on S5 |
| ready | input | 1 | Transfer-complete acknowledge, active high |
| hold_req | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus handed over |
| ad_in | input | 16 | Values seen on the low lines |
| ad_out | output | 16 | Value driven on the low lines |
| ad_oe | output | 1 | Drive enable for the low lines |
| ast_out | output | 4 | Upper address / status lines |
| ast_oe | output | 1 | Drive enable for the upper lines |
| bhe_n | output | 1 | High-byte enable, active low / status S7 |
| bhe_oe | output | 1 | Drive enable for `bhe_n` |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Drive enable for `rd_n` |
| rsp_valid | output | 1 | Read data available (T4 of a read) |
| rsp_rdata | output | 16 | Captured read data |

## Verification
Every pin value depends only on the registered phase, the request fields latched at acceptance and the registered interrupt-enable bit. A request or hold accepted at an edge therefore shows on the pins in the very next cycle. A ready level changes the phase one edge later. A change of `ie_flag` reaches S5 after one edge. The bench drives inputs on the falling edge. At each rising edge it advances a behavioural model from the same inputs, and it compares every output two nanoseconds later. Each expected value thus matches the cycle in which the registers have just moved. Directed runs add a count of read-strobe cycles under a stretched ready, and the exact cycle in which a hold raised during a write is granted.

// File: rtl/mux_bus_pkg.sv
// Shared types of the multiplexed bus sequencer.
// Assumes one T-state per clock cycle.
package mux_bus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5,
        PH_HOLD = 3'd6
    } bus_ph_e;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_code_e;

    // True in the states where the lines carry data or status
    function automatic logic ph_is_data(bus_ph_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/mux_bus_ctrl.sv
// Phase sequencer and request latch.
// Accepts a request in idle or T4 when no hold is pending, then steps
// T1, T2, T3, Tw while ready is low, and T4. Grants a hold only between
// machine cycles. Assumes ready is already synchronous to clk.
module mux_bus_ctrl
    import mux_bus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_hi_byte,
    input  logic [1:0]        req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold_req,
    output logic              req_ready,
    output bus_ph_e           ph,
    output logic [ADDR_W-1:0] addr_q,
    output logic              io_q,
    output logic              wr_q,
    output logic              hi_q,
    output logic [1:0]        seg_q,
    output logic [DATA_W-1:0] wdata_q
);

    bus_ph_e ph_q, ph_d;
    logic    accept;

    // Boundary between cycles: the only place a new owner may take the bus
    assign req_ready = ((ph_q == PH_IDLE) || (ph_q == PH_T4)) && !hold_req;
    assign accept    = req_valid && req_ready;
    assign ph        = ph_q;

    // Next-phase decision
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: begin
                if (hold_req)       ph_d = PH_HOLD;
                else if (req_valid) ph_d = PH_T1;
            end
            PH_T1:   ph_d = PH_T2;
            PH_T2:   ph_d = PH_T3;
            PH_T3,
            PH_TW:   ph_d = ready ? PH_T4 : PH_TW;
            PH_T4: begin
                if (hold_req)       ph_d = PH_HOLD;
                else if (req_valid) ph_d = PH_T1;
                else                ph_d = PH_IDLE;
            end
            PH_HOLD: ph_d = hold_req ? PH_HOLD : PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Request fields captured at acceptance, held for the whole cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            io_q    <= 1'b0;
            wr_q    <= 1'b0;
            hi_q    <= 1'b0;
            seg_q   <= SEG_CODE;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            io_q    <= req_io;
            wr_q    <= req_write;
            hi_q    <= req_hi_byte;
            seg_q   <= req_seg;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/mux_bus_status.sv
// Upper address / status lane former.
// T1 shows the top address bits (zero for I/O). The data phases show
// {S6=0, S5=ie, S4S3=segment}. Assumes HI_W is at least 4.
module mux_bus_status
    import mux_bus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_flag,
    input  bus_ph_e         ph,
    input  logic            io_q,
    input  logic [1:0]      seg_q,
    input  logic [HI_W-1:0] addr_hi,
    output logic [HI_W-1:0] ast_out
);

    logic            ie_q;
    logic [1:0]      seg_eff;
    logic [HI_W-1:0] stat_vec;

    // Interrupt-enable status refreshed at every edge
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else        ie_q <= ie_flag;
    end

    // I/O cycles report the code/none segment code
    assign seg_eff = io_q ? SEG_CODE : seg_q;

    // Status word: bits 1..0 segment, bit 2 interrupt enable, rest low
    always_comb begin
        stat_vec    = '0;
        stat_vec[0] = seg_eff[0];
        stat_vec[1] = seg_eff[1];
        stat_vec[2] = ie_q;
    end

    // Per-line multiplexer between address, status and idle zero
    for (genvar b = 0; b < HI_W; b++) begin : g_lane
        always_comb begin
            if (ph == PH_T1)          ast_out[b] = io_q ? 1'b0 : addr_hi[b];
            else if (ph_is_data(ph))  ast_out[b] = stat_vec[b];
            else                      ast_out[b] = 1'b0;
        end
    end

endmodule

// File: rtl/mux_bus_pins.sv
// Low-lane, strobe and enable former, with the read-data capture register.
// The low lines carry the address in T1 and write data in the data phases.
// For reads they turn around and float. Every driven pin floats in hold.
module mux_bus_pins
    import mux_bus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ph_e           ph,
    input  logic              wr_q,
    input  logic              hi_q,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              ready,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ast_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              rd_oe,
    output logic              hlda,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic data_ph;
    logic in_hold;
    logic wr_drive;
    logic [DATA_W-1:0] rdata_q;

    assign data_ph  = ph_is_data(ph);
    assign in_hold  = (ph == PH_HOLD);
    assign wr_drive = data_ph && wr_q;

    // Low-lane value and enable
    always_comb begin
        if (ph == PH_T1)   ad_out = addr_lo;
        else if (wr_drive) ad_out = wdata_q;
        else               ad_out = '0;
        ad_oe = (ph == PH_T1) || wr_drive;
    end

    // Strobes: address latch in T1, read strobe in T2/T3/Tw of reads
    always_comb begin
        ale   = (ph == PH_T1);
        rd_n  = !(!wr_q && ((ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW)));
        bhe_n = (ph == PH_T1) ? !hi_q : 1'b1;
    end

    // Drive enables released only while the bus is handed over
    always_comb begin
        ast_oe = !in_hold;
        bhe_oe = !in_hold;
        rd_oe  = !in_hold;
        hlda   = in_hold;
    end

    // Read data taken at the edge where ready completes the transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (((ph == PH_T3) || (ph == PH_TW)) && ready && !wr_q)
            rdata_q <= ad_in;
    end

    assign rsp_valid = (ph == PH_T4) && !wr_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed address/data bus sequencer.
// Joins the phase sequencer, the upper-lane status former and the pin
// former. Pins are exposed as value plus drive-enable pairs.
module mux_bus_seq
    import mux_bus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_hi_byte,
    input  logic [1:0]        req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ie_flag,
    input  logic              ready,
    input  logic              hold_req,
    output logic              hlda,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ast_out,
    output logic              ast_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              rd_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    bus_ph_e           ph;
    logic [ADDR_W-1:0] addr_q;
    logic              io_q, wr_q, hi_q;
    logic [1:0]        seg_q;
    logic [DATA_W-1:0] wdata_q;

    mux_bus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_io      (req_io),
        .req_write   (req_write),
        .req_hi_byte (req_hi_byte),
        .req_seg     (req_seg),
        .req_wdata   (req_wdata),
        .ready       (ready),
        .hold_req    (hold_req),
        .req_ready   (req_ready),
        .ph          (ph),
        .addr_q      (addr_q),
        .io_q        (io_q),
        .wr_q        (wr_q),
        .hi_q        (hi_q),
        .seg_q       (seg_q),
        .wdata_q     (wdata_q)
    );

    mux_bus_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie_flag (ie_flag),
        .ph      (ph),
        .io_q    (io_q),
        .seg_q   (seg_q),
        .addr_hi (addr_q[ADDR_W-1:DATA_W]),
        .ast_out (ast_out)
    );

    mux_bus_pins #(.DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .wr_q      (wr_q),
        .hi_q      (hi_q),
        .addr_lo   (addr_q[DATA_W-1:0]),
        .wdata_q   (wdata_q),
        .ad_in     (ad_in),
        .ready     (ready),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ast_oe    (ast_oe),
        .bhe_n     (bhe_n),
        .bhe_oe    (bhe_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .rd_oe     (rd_oe),
        .hlda      (hlda),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/mux_bus_seq_chk.sv
// Property checker for the bus sequencer, bound to every instance of the top.
// Assumes HI_W is at least 4, so that S5 sits on bit 2.
module mux_bus_seq_chk
    import mux_bus_pkg::*;
#(
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input bus_ph_e         ph,
    input logic            req_valid,
    input logic            req_ready,
    input logic            ready,
    input logic            ie_flag,
    input logic            hlda,
    input logic            ale,
    input logic            rd_n,
    input logic            ad_oe,
    input logic            ast_oe,
    input logic            bhe_oe,
    input logic            rd_oe,
    input logic [HI_W-1:0] ast_out
);

    AST_ACCEPT_STARTS_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ale); // R1
    AST_ALE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
    AST_S6_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ph_is_data(ph) |-> !ast_out[HI_W-1]); // R5
    AST_S5_FOLLOWS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_is_data(ph) |-> (ast_out[2] == $past(ie_flag))); // R6
    AST_RD_WITH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R8
    AST_WAIT_INSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (((ph == PH_T3) || (ph == PH_TW)) && !ready) |=> (ph == PH_TW)); // R9
    AST_WAIT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (((ph == PH_T3) || (ph == PH_TW)) && ready) |=> (ph == PH_T4)); // R9
    AST_HOLD_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !ast_oe && !bhe_oe && !rd_oe)); // R11
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> (($past(ph) == PH_IDLE) || ($past(ph) == PH_T4))); // R11

endmodule

bind mux_bus_seq mux_bus_seq_chk #(.HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ready     (ready),
    .ie_flag   (ie_flag),
    .hlda      (hlda),
    .ale       (ale),
    .rd_n      (rd_n),
    .ad_oe     (ad_oe),
    .ast_oe    (ast_oe),
    .bhe_oe    (bhe_oe),
    .rd_oe     (rd_oe),
    .ast_out   (ast_out)
);

// File: tb/mux_bus_seq_test.sv
// Bench: a behavioural phase model stepped at every rising edge and
// compared with all outputs 2 ns later. Inputs change on falling edges.
module mux_bus_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [19:0] req_addr;
    logic        req_io, req_write, req_hi_byte;
    logic [1:0]  req_seg;
    logic [15:0] req_wdata;
    logic        ie_flag, ready, hold_req, hlda;
    logic [15:0] ad_in, ad_out;
    logic        ad_oe;
    logic [3:0]  ast_out;
    logic        ast_oe, bhe_n, bhe_oe, ale, rd_n, rd_oe, rsp_valid;
    logic [15:0] rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_lo_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mux_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_io(req_io), .req_write(req_write),
        .req_hi_byte(req_hi_byte), .req_seg(req_seg), .req_wdata(req_wdata),
        .ie_flag(ie_flag), .ready(ready), .hold_req(hold_req), .hlda(hlda),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ast_out(ast_out),
        .ast_oe(ast_oe), .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ale(ale),
        .rd_n(rd_n), .rd_oe(rd_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model: phase 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4, 6 hold
    int          m_ph = 0;
    logic [19:0] m_addr = '0;
    logic        m_io = 0, m_wr = 0, m_hi = 0, m_ie = 0;
    logic [1:0]  m_seg = 2'b10;
    logic [15:0] m_wdata = '0, m_rdata = '0;
    bit          m_live = 0;

    function automatic bit m_rdy(int p, logic h);
        return ((p == 0) || (p == 5)) && !h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ie = 0; m_rdata = '0; m_live = 1;
            m_addr = '0; m_io = 0; m_wr = 0; m_hi = 0; m_seg = 2'b10; m_wdata = '0;
        end else if (m_live) begin
            bit acc;
            int nx;
            acc = req_valid && m_rdy(m_ph, hold_req);
            if ((m_ph == 3 || m_ph == 4) && ready && !m_wr) m_rdata = ad_in;
            nx = m_ph;
            case (m_ph)
                0: nx = hold_req ? 6 : (req_valid ? 1 : 0);
                1: nx = 2;
                2: nx = 3;
                3, 4: nx = ready ? 5 : 4;
                5: nx = hold_req ? 6 : (req_valid ? 1 : 0);
                default: nx = hold_req ? 6 : 0;
            endcase
            if (acc) begin
                m_addr = req_addr; m_io = req_io; m_wr = req_write;
                m_hi = req_hi_byte; m_seg = req_seg; m_wdata = req_wdata;
            end
            m_ie = ie_flag;
            m_ph = nx;
        end
        #2;
        if (m_live) compare();
    end

    task automatic compare();
        bit dp;
        logic [3:0] e_ast;
        logic [15:0] e_ad;
        dp = (m_ph >= 2 && m_ph <= 5);
        check("R1 req_ready", req_ready, m_rdy(m_ph, hold_req));
        check("R2 ale", ale, m_ph == 1);
        e_ad = (m_ph == 1) ? m_addr[15:0] : ((dp && m_wr) ? m_wdata : 16'h0);
        check("R3 ad_oe", ad_oe, (m_ph == 1) || (dp && m_wr));
        check("R3 ad_out", ad_out, e_ad);
        if (m_ph == 1) begin
            e_ast = m_io ? 4'h0 : m_addr[19:16];
            check("R4 ast_out", ast_out, e_ast);
        end else begin
            e_ast = dp ? {1'b0, m_ie, (m_io ? 2'b10 : m_seg)} : 4'h0;
            check("R5 ast_out", ast_out, e_ast);
            if (dp) check("R6 s5", ast_out[2], m_ie);
        end
        check("R7 bhe_n", bhe_n, (m_ph == 1) ? !m_hi : 1'b1);
        check("R8 rd_n", rd_n, !(!m_wr && (m_ph >= 2 && m_ph <= 4)));
        check("R10 rsp_valid", rsp_valid, (m_ph == 5) && !m_wr);
        if (m_ph == 5 && !m_wr) check("R10 rsp_rdata", rsp_rdata, m_rdata);
        check("R11 hlda", hlda, m_ph == 6);
        check("R11 oe", {ast_oe, bhe_oe, rd_oe}, (m_ph == 6) ? 3'b000 : 3'b111);
        if (!rd_n) rd_lo_cnt++;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_addr = '0; req_io = 0; req_write = 0;
        req_hi_byte = 0; req_seg = 0; req_wdata = '0; ie_flag = 0; ready = 1;
        hold_req = 0; ad_in = '0;
        repeat (5) @(negedge clk);
        // R12: reset state
        check("R12 hlda", hlda, 0);
        check("R12 ale", ale, 0);
        check("R12 rd_n", rd_n, 1);
        check("R12 ad_oe", ad_oe, 0);
        rst_n = 1;
        ie_flag = 1;
        @(negedge clk);
        check("R12 s5 after reset", uut.ast_out[2], 0);

        // R9: memory read stretched by three wait states
        rd_lo_cnt = 0;
        req_valid = 1; req_addr = 20'hA5C3E; req_io = 0; req_write = 0;
        req_hi_byte = 1; req_seg = 2'b11; ad_in = 16'hBEEF; ready = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (5) @(negedge clk);
        ready = 1;
        repeat (4) @(negedge clk);
        check("R9 read strobe cycles", rd_lo_cnt, 5);

        // R11: hold raised during a write is granted only after T4
        req_valid = 1; req_write = 1; req_io = 1; req_addr = 20'h0037C;
        req_wdata = 16'h1234; req_hi_byte = 0;
        @(negedge clk);
        req_valid = 0; hold_req = 1;
        repeat (3) @(negedge clk);
        check("R11 no grant in T4", hlda, 0);
        @(negedge clk);
        check("R11 grant after T4", hlda, 1);
        check("R11 low lines float", ad_oe, 0);
        repeat (3) @(negedge clk);
        hold_req = 0;
        @(negedge clk);
        check("R11 release", hlda, 0);

        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            req_valid   = ($urandom % 3) != 0;
            req_addr    = 20'($urandom);
            req_io      = ($urandom % 4) == 0;
            req_write   = $urandom % 2;
            req_hi_byte = $urandom % 2;
            req_seg     = 2'($urandom);
            req_wdata   = 16'($urandom);
            ad_in       = 16'($urandom);
            ready       = ($urandom % 4) != 0;
            if (($urandom % 5) == 0) ie_flag = ~ie_flag;
            if (($urandom % 12) == 0) hold_req = ~hold_req;
        end
        hold_req = 0; req_valid = 0; ready = 1;
        repeat (10) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule